// File: doc/BRIEF.md
# Write Status Read-Back Multiplexer

This block sits on the read path of a byte-wide non-volatile memory that has a page-load phase and an internally timed programming phase. While the memory is idle, a qualified read returns the array data unchanged. While a page is being loaded or programmed, a qualified read returns three completion-status bits in the top of the byte instead of array data. The bits are a polling bit, a toggling bit and a load-timer bit. The lower bits are left undriven.

The external write sequencer supplies two flags. One says the page-load timer is running; the other says programming is under way. The block watches the bus strobes to capture the most significant bit of the last byte written. It also keeps a toggle flip-flop that advances at the end of every status read. The data bus is modelled as a value plus a per-bit drive enable, and the enables are all low whenever the output or chip enable is inactive.

Top module: `status_readback`

## Requirements
- R1: `dq_oe_o` is all zeros unless a qualified read is present (`ce_ni`=0, `oe_ni`=0, `we_ni`=1); with either `ce_ni` or `oe_ni` high the bus is never driven.
- R2: On a qualified read with `load_active_i`=0 and `prog_busy_i`=0, `dq_o` equals `arr_data_i`, `dq_oe_o` is all ones and `stat_vld_o` is 0.
- R3: On a qualified read with `load_active_i` or `prog_busy_i` high, `stat_vld_o` is 1, and `dq_oe_o` drives only the three top bits (bits DW-1..DW-3, i.e. 8'hE0 for DW=8).
- R4: During a status read, bit DW-1 is the inverse of bit DW-1 of the most recent written byte. A write is a clock edge with `ce_ni`=0, `we_ni`=0, `oe_ni`=1. After reset, the stored bit is 0.
- R5: During a busy period, bit DW-2 of a status read flips once after each qualified read ends (read present at one clock edge, absent at the next); it is steady within one continuous read.
- R6: Bit DW-2 is forced to 0 whenever the block is idle at a clock edge, so the first status read of every new busy period returns 0.
- R7: During a status read, bit DW-3 is 0 while `load_active_i` is high and 1 while only `prog_busy_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| wdata_i | input | DW | Byte presented by the host on a write |
| arr_data_i | input | DW | Byte read from the array |
| load_active_i | input | 1 | Page-load timer running |
| prog_busy_i | input | 1 | Internal programming in progress |
| dq_o | output | DW | Read data or status |
| dq_oe_o | output | DW | Per-bit output drive enable |
| stat_vld_o | output | 1 | Status is being returned instead of data |

## Verification
The bench targets the first status read after idle. A toggle that is not cleared between busy periods would return 1 there. It checks reads held across several clocks, where a toggle advancing on the read level rather than its end would flip mid-read. It checks the polling bit after writes with both values of the top bit, which catches a missing inversion or a stale capture. It checks the load-to-program hand-off for the timer bit, and it checks undriven low bits during status, which a mux that enables the whole byte would fail.

// File: rtl/status_rb_pkg.sv
package status_rb_pkg;
  localparam int unsigned STAT_BITS = 3;

  typedef struct packed {
    logic poll;
    logic tgl;
    logic tmr;
  } stat_t;
endpackage

// File: rtl/srb_bus_decode.sv
module srb_bus_decode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic rd_o,
  output logic wr_o,
  output logic rd_end_o
);
  logic rd_q;

  assign rd_o = ~ce_ni & ~oe_ni & we_ni;
  assign wr_o = ~ce_ni & ~we_ni & oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_o;
  end

  // end of a read seen at this edge
  assign rd_end_o = rd_q & ~rd_o;
endmodule

// File: rtl/srb_status_track.sv
module srb_status_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wmsb_i,
  input  logic rd_end_i,
  input  logic busy_i,
  output logic poll_o,
  output logic tgl_o
);
  logic msb_q;
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   msb_q <= 1'b0;
    else if (wr_i) msb_q <= wmsb_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tgl_q <= 1'b0;
    else if (!busy_i)  tgl_q <= 1'b0;
    else if (rd_end_i) tgl_q <= ~tgl_q;
  end

  assign poll_o = ~msb_q;
  assign tgl_o  = tgl_q;
endmodule

// File: rtl/srb_read_mux.sv
module srb_read_mux
  import status_rb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          rd_i,
  input  logic          busy_i,
  input  stat_t         stat_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] dq_oe_o,
  output logic          stat_vld_o
);
  localparam int unsigned STAT_LO = DW - STAT_BITS;

  logic [STAT_BITS-1:0] stat_vec;
  assign stat_vec   = {stat_i.poll, stat_i.tgl, stat_i.tmr};
  assign stat_vld_o = rd_i & busy_i;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b >= STAT_LO) begin : g_stat
      assign dq_o[b]    = busy_i ? stat_vec[b-STAT_LO] : arr_data_i[b];
      assign dq_oe_o[b] = rd_i;
    end else begin : g_plain
      // undriven while status is shown
      assign dq_o[b]    = busy_i ? 1'b0 : arr_data_i[b];
      assign dq_oe_o[b] = rd_i & ~busy_i;
    end
  end
endmodule

// File: rtl/status_readback.sv
module status_readback
  import status_rb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic          load_active_i,
  input  logic          prog_busy_i,
  output logic [DW-1:0] dq_o,
  output logic [DW-1:0] dq_oe_o,
  output logic          stat_vld_o
);
  logic rd, wr, rd_end, busy;
  stat_t stat;

  assign busy = load_active_i | prog_busy_i;

  srb_bus_decode i_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .rd_o     (rd),
    .wr_o     (wr),
    .rd_end_o (rd_end)
  );

  srb_status_track i_trk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wmsb_i   (wdata_i[DW-1]),
    .rd_end_i (rd_end),
    .busy_i   (busy),
    .poll_o   (stat.poll),
    .tgl_o    (stat.tgl)
  );

  // timer bit: high once loading window has closed
  assign stat.tmr = ~load_active_i;

  srb_read_mux #(.DW(DW)) i_mux (
    .rd_i       (rd),
    .busy_i     (busy),
    .stat_i     (stat),
    .arr_data_i (arr_data_i),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o),
    .stat_vld_o (stat_vld_o)
  );
endmodule

// File: rtl/status_readback_chk.sv
module status_readback_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_ni,
  input logic          oe_ni,
  input logic          we_ni,
  input logic [DW-1:0] arr_data_i,
  input logic          load_active_i,
  input logic          prog_busy_i,
  input logic [DW-1:0] dq_o,
  input logic [DW-1:0] dq_oe_o,
  input logic          stat_vld_o
);
  localparam logic [DW-1:0] STAT_MASK = {3'b111, {(DW-3){1'b0}}};

  logic rd_l, busy_l;
  assign rd_l   = !ce_ni && !oe_ni && we_ni;
  assign busy_l = load_active_i || prog_busy_i;

  assert_bus_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> dq_oe_o == '0);

  assert_idle_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_l && !busy_l) |-> (dq_o == arr_data_i && dq_oe_o == '1 && !stat_vld_o));

  assert_stat_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_vld_o |-> (busy_l && dq_oe_o == STAT_MASK));

  assert_tgl_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_vld_o && $past(stat_vld_o)) |-> dq_o[DW-2] == $past(dq_o[DW-2]));

  assert_tgl_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_vld_o && !$past(busy_l)) |-> !dq_o[DW-2]);

  assert_tmr_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_vld_o |-> dq_o[DW-3] == !load_active_i);
endmodule

bind status_readback status_readback_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_status_readback.sv
module test_status_readback;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ld = 1'b0, pb = 1'b0;
  logic [DW-1:0] wd = '0, arr = '0;
  logic [DW-1:0] dq, dq_oe;
  logic stat_vld;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  status_readback #(.DW(DW)) i_status_readback (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .wdata_i(wd), .arr_data_i(arr), .load_active_i(ld), .prog_busy_i(pb),
    .dq_o(dq), .dq_oe_o(dq_oe), .stat_vld_o(stat_vld));

  // reference state from the requirements
  logic m_b7, m_tgl, m_prd, m_pbusy;
  function automatic logic rd_now(); return !ce_n && !oe_n && we_n; endfunction
  function automatic logic busy_now(); return ld || pb; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_b7 <= 1'b0; m_tgl <= 1'b0; m_prd <= 1'b0; m_pbusy <= 1'b0;
    end else begin
      if (!ce_n && !we_n && oe_n) m_b7 <= wd[DW-1];
      if (!busy_now()) m_tgl <= 1'b0;
      else if (m_prd && !rd_now()) m_tgl <= ~m_tgl;
      m_prd   <= rd_now();
      m_pbusy <= busy_now();
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    if (!rd_now()) begin
      chk("R1 oe", dq_oe, '0);
    end else if (!busy_now()) begin
      chk("R2 oe", dq_oe, '1);
      chk("R2 data", dq, arr);
      chk("R2 vld", {7'd0, stat_vld}, 8'd0);
    end else begin
      chk("R3 oe", dq_oe, 8'hE0);
      chk("R3 vld", {7'd0, stat_vld}, 8'd1);
      chk("R4 poll", {7'd0, dq[7]}, {7'd0, ~m_b7});
      if (!m_pbusy) chk("R6 tgl", {7'd0, dq[6]}, 8'd0);
      else          chk("R5 tgl", {7'd0, dq[6]}, {7'd0, m_tgl});
      chk("R7 tmr", {7'd0, dq[5]}, {7'd0, ~ld});
    end
  endtask

  task automatic step(input logic c, input logic o, input logic w,
                      input logic [DW-1:0] d, input logic [DW-1:0] a,
                      input logic l, input logic p);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; wd = d; arr = a; ld = l; pb = p;
    #2 check_all();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // reset state: bus off, no status (R1)
    #10;
    chk("R1 reset oe", dq_oe, '0);
    chk("R3 reset vld", {7'd0, stat_vld}, 8'd0);
    @(negedge clk); rst_n = 1'b1;

    step(1'b0, 1'b0, 1'b1, 8'h00, 8'h5A, 1'b0, 1'b0);   // R2 idle read
    step(1'b0, 1'b1, 1'b1, 8'h00, 8'h5A, 1'b0, 1'b0);   // R1 oe high
    step(1'b0, 1'b1, 1'b0, 8'h80, 8'h5A, 1'b0, 1'b0);   // write msb 1
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 1'b1, 1'b0);   // R6 first read 0, R4 poll 0
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 1'b1, 1'b0);   // R5 held read steady
    step(1'b1, 1'b0, 1'b1, 8'h00, 8'hA5, 1'b1, 1'b0);   // R1 ce high
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 1'b1, 1'b0);   // R5 now 1
    step(1'b0, 1'b1, 1'b1, 8'h00, 8'hA5, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'hA5, 1'b0, 1'b1);   // R5 0, R7 tmr 1
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b0, 1'b0);   // R2 done
    step(1'b0, 1'b1, 1'b0, 8'h7F, 8'h3C, 1'b0, 1'b0);   // write msb 0
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b0, 1'b1);   // R6 restart, R4 poll 1
    step(1'b0, 1'b1, 1'b1, 8'h00, 8'h3C, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1, 8'h00, 8'h3C, 1'b1, 1'b1);   // R7 tmr 0 while loading

    for (int i = 0; i < 4000; i++) begin
      logic c, o, w, l, p;
      c = ($urandom % 5) == 0;
      o = ($urandom % 4) == 0;
      w = ($urandom % 6) != 0;
      l = ld; p = pb;
      if (($urandom % 12) == 0) l = ~ld;
      if (($urandom % 12) == 0) p = ~pb;
      step(c, o, w, 8'($urandom), 8'($urandom), l, p);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule